// File: doc/BRIEF.md
# Folded Radix-4 Digit-Serial FIR Filter

This block is a programmable finite impulse response filter with 128 taps, signed 10-bit samples and signed 10-bit coefficients. The multiplier count is cut by folding along two axes. The taps are split into two halves, and each half shares one bank of 64 multiply units. Each sample is also consumed one radix-4 Booth digit at a time. A 10-bit sample has five digits, so every sample takes a frame of ten clock cycles. In each cycle one tap half is paired with one digit position. The per-cycle partial products are summed by a balanced adder tree, shifted by the digit weight and added into a running accumulator.

The filter history is a shift register that keeps each sample as five 2-bit fields. The 3-bit Booth group for digit i is assembled only when it is needed, by borrowing the top bit of field i-1 (zero for the lowest digit). Coefficients are written into a staging bank through a simple address/data/strobe port. The staging bank is copied into the working bank at the edge where a sample is accepted, so a write never disturbs a frame already in flight.

Samples enter on a valid/ready handshake. A producer holds `in_valid` and `in_data` until it sees `in_ready` high at a rising edge. `in_ready` may fall while `in_valid` is low. The result side has no back-pressure: `out_valid` is a single-cycle strobe, and the consumer must take `out_data` in that cycle.

Top module: `fir_booth_fold`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, `in_ready` is 1, and the history and both coefficient banks hold zeros, so a first sample gives a result of 0 unless coefficients have been written.
- R2: A sample is accepted only at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after an acceptance until the last cycle of that frame. `in_data` has no effect on any result when it is not accepted.
- R3: For accepted samples x[n] (newest), x[n-1], ..., the result is the sum over k = 0..127 of c[k]·x[n-k]. Here c[k] is the coefficient at address k, and history from before reset counts as zero. All values are two's complement.
- R4: Each accepted sample produces exactly one result. `out_valid` is high for one cycle, in the cycle after the 10th rising edge that follows the accepting edge. No strobe appears without a matching acceptance.
- R5: `in_ready` is 1 during the last cycle of a frame, so a continuously offered stream is accepted every 10 cycles.
- R6: A coefficient write (`coef_we` = 1 at a rising edge) stores `coef_wdata` at `coef_addr`. It is first used by the next sample accepted at a later edge. A frame already in progress keeps the coefficients it started with.
- R7: The most negative sample and coefficient (-512) are handled exactly. 128 products of (-512)·(-512) give 33554432 in the 27-bit output without overflow.
- R8: `out_data` holds its value in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Tap index being written |
| coef_wdata | input | 10 | Signed coefficient value |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 10 | Signed sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 27 | Signed filter result |

## Verification
Each result is due a fixed ten rising edges after the edge that accepted its sample. The bench records that edge number together with the expected sum, and checks the strobe at the falling edge after the tenth following rising edge. The driver computes both values in the falling-edge half cycle before the accepting edge. It applies the staging-to-working copy at that moment, so a coefficient write that lands on the same edge is correctly kept out. The monitor samples every falling edge. It flags a strobe that arrives early, late or unexpectedly, and it flags any change of `out_data` between strobes.

// File: rtl/fir_fold_pkg.sv
`timescale 1ns/1ps
package fir_fold_pkg;

  typedef enum logic [2:0] {
    BD_ZERO,
    BD_POS1,
    BD_POS2,
    BD_NEG1,
    BD_NEG2
  } booth_dig_t;

  // Map a 3-bit group {b(2i+1), b(2i), b(2i-1)} to a radix-4 digit.
  function automatic booth_dig_t booth_recode(input logic [2:0] grp);
    case (grp)
      3'b001, 3'b010: return BD_POS1;
      3'b011:         return BD_POS2;
      3'b100:         return BD_NEG2;
      3'b101, 3'b110: return BD_NEG1;
      default:        return BD_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/fir_booth_pp.sv
`timescale 1ns/1ps
module fir_booth_pp #(
  parameter int CW  = 10,
  parameter int PPW = CW + 2
) (
  input  logic [2:0]            grp,
  input  logic signed [CW-1:0]  coef,
  output logic signed [PPW-1:0] pp,
  output logic                  neg
);
  import fir_fold_pkg::*;

  booth_dig_t             dig;
  logic signed [PPW-1:0]  cext;
  logic signed [PPW-1:0]  mag;

  always_comb begin
    dig  = booth_recode(grp);
    cext = PPW'(coef);
    mag  = '0;
    neg  = 1'b0;
    case (dig)
      BD_POS1: mag = cext;
      BD_POS2: mag = cext <<< 1;
      BD_NEG1: begin mag = cext;       neg = 1'b1; end
      BD_NEG2: begin mag = cext <<< 1; neg = 1'b1; end
      default: mag = '0;
    endcase
    // Negation is one's complement here; the +1 is added once in the tree.
    pp = neg ? ~mag : mag;
  end

endmodule

// File: rtl/fir_pp_tree.sv
`timescale 1ns/1ps
module fir_pp_tree #(
  parameter int N   = 64,
  parameter int PPW = 12,
  localparam int LV   = $clog2(N),
  localparam int TW   = PPW + LV,
  localparam int CNTW = $clog2(N + 1)
) (
  input  logic signed [PPW-1:0] pp [N],
  input  logic [N-1:0]          neg,
  output logic signed [TW-1:0]  sum
);

  logic [CNTW-1:0] ncnt;

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    logic signed [TW-1:0] v [N >> l];
    if (l == 0) begin : g_in
      for (genvar k = 0; k < N; k++) begin : g_k
        assign v[k] = TW'(pp[k]);
      end
    end else begin : g_add
      for (genvar k = 0; k < (N >> l); k++) begin : g_k
        assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
      end
    end
  end

  always_comb begin
    ncnt = '0;
    for (int k = 0; k < N; k++) ncnt = ncnt + CNTW'(neg[k]);
  end

  // All deferred +1 terms enter in one addition at the root.
  assign sum = g_lvl[LV].v[0] + $signed(TW'(ncnt));

endmodule

// File: rtl/fir_seq.sv
`timescale 1ns/1ps
module fir_seq #(
  parameter int FRAME = 10,
  localparam int SW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [SW-1:0] step
);

  logic          busy_q;
  logic [SW-1:0] step_q;

  assign busy     = busy_q;
  assign step     = step_q;
  assign last     = busy_q && (step_q == SW'(FRAME - 1));
  assign in_ready = !busy_q || last;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (last) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
    end
  end

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(step_q) < FRAME));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

endmodule

// File: rtl/fir_booth_fold.sv
`timescale 1ns/1ps
module fir_booth_fold #(
  parameter int TAPS     = 128,
  parameter int DW       = 10,
  parameter int CW       = 10,
  parameter int TAP_FOLD = 2,
  localparam int AW     = $clog2(TAPS),
  localparam int ACCW   = DW + CW + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            coef_we,
  input  logic [AW-1:0]   coef_addr,
  input  logic [CW-1:0]   coef_wdata,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  output logic [ACCW-1:0] out_data
);

  localparam int DIGITS = DW / 2;
  localparam int FRAME  = TAP_FOLD * DIGITS;
  localparam int UNITS  = TAPS / TAP_FOLD;
  localparam int PPW    = CW + 2;
  localparam int TW     = PPW + $clog2(UNITS);
  localparam int SW     = $clog2(FRAME);
  localparam int HW     = (TAP_FOLD > 1) ? $clog2(TAP_FOLD) : 1;
  localparam int DGW    = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  // Sequencing
  logic          accept, busy, last;
  logic [SW-1:0] step;
  logic [HW-1:0] half;
  logic [DGW-1:0] digit;

  fir_seq #(.FRAME(FRAME)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .busy     (busy),
    .last     (last),
    .step     (step)
  );

  always_comb begin
    half  = HW'(int'(step) / DIGITS);
    digit = DGW'(int'(step) % DIGITS);
  end

  // History: each sample kept as DIGITS fields of 2 bits, newest at index 0
  logic [TAPS-1:0][DIGITS-1:0][1:0] line;

  always_ff @(posedge clk) begin
    if (!rst_n)      line <= '0;
    else if (accept) line <= {line[TAPS-2:0], in_data};
  end

  // Coefficients: staging bank written by the port, working bank copied on accept
  logic [TAPS-1:0][CW-1:0] coef_stg;
  logic [TAPS-1:0][CW-1:0] coef_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_stg <= '0;
      coef_act <= '0;
    end else begin
      if (coef_we) coef_stg[coef_addr] <= coef_wdata;
      if (accept)  coef_act <= coef_stg;
    end
  end

  // Shared multiply bank
  logic signed [PPW-1:0] pp_arr [UNITS];
  logic [UNITS-1:0]      neg_arr;

  for (genvar j = 0; j < UNITS; j++) begin : g_unit
    logic [DW-1:0] xs;
    logic [CW-1:0] cs;
    logic [DW:0]   ext;
    logic [2:0]    grp;

    always_comb begin
      xs = line[j];
      cs = coef_act[j];
      for (int h = 1; h < TAP_FOLD; h++) begin
        if (half == HW'(h)) begin
          xs = line[h*UNITS + j];
          cs = coef_act[h*UNITS + j];
        end
      end
      // Overlap bit comes from the neighbouring lower field (zero below field 0)
      ext = {xs, 1'b0};
      grp = ext[2*digit +: 3];
    end

    fir_booth_pp #(.CW(CW), .PPW(PPW)) u_pp (
      .grp  (grp),
      .coef ($signed(cs)),
      .pp   (pp_arr[j]),
      .neg  (neg_arr[j])
    );
  end

  logic signed [TW-1:0] psum;

  fir_pp_tree #(.N(UNITS), .PPW(PPW)) u_tree (
    .pp  (pp_arr),
    .neg (neg_arr),
    .sum (psum)
  );

  // Weight by digit position and accumulate
  logic signed [ACCW-1:0] pext;
  logic signed [ACCW-1:0] weighted;
  logic signed [ACCW-1:0] acc;

  always_comb begin
    pext     = ACCW'(psum);
    weighted = pext <<< (2 * digit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        if (step == '0) acc <= weighted;
        else            acc <= acc + weighted;
        if (last) begin
          out_valid <= 1'b1;
          out_data  <= acc + weighted;
        end
      end
    end
  end

  // R4
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R6
  coef_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(coef_act));

  // R3
  line_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (line[0] == $past(in_data)));

endmodule

// File: tb/test_fir_booth_fold.sv
`timescale 1ns/1ps
module test_fir_booth_fold;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coef_we = 1'b0;
  logic [6:0]  coef_addr = '0;
  logic [9:0]  coef_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_data = '0;
  logic        out_valid;
  logic [26:0] out_data;

  fir_booth_fold i_fir_booth_fold (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  always #2.5 clk = ~clk;

  int     cyc = 0;
  int     nchk = 0;
  int     nfail = 0;
  int     stg_m [128];
  int     act_m [128];
  int     hist [128];
  longint exp_q [$];
  int     due_q [$];
  int     last_acc = 0;
  longint last_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int x);
    longint e;
    in_valid = 1'b1;
    in_data  = 10'(x);
    while (!in_ready) @(negedge clk);
    act_m = stg_m;
    for (int k = 127; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    e = 0;
    for (int k = 0; k < 128; k++) e += longint'(act_m[k]) * longint'(hist[k]);
    exp_q.push_back(e);
    due_q.push_back(cyc + 11);
    last_acc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 10'($urandom);
  endtask

  task automatic wcoef(input int a, input int v);
    coef_we    = 1'b1;
    coef_addr  = 7'(a);
    coef_wdata = 10'(v);
    @(posedge clk);
    stg_m[a] = v;
    @(negedge clk);
    coef_we    = 1'b0;
    coef_wdata = 10'($urandom);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4 strobe without sample", 1, 0);
          end else begin
            longint e;
            int     d;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            chk(longint'($signed(out_data)) == e, "R3 result", longint'($signed(out_data)), e);
            chk(cyc == d, "R4 result timing", cyc, d);
          end
          last_out = longint'($signed(out_data));
        end else begin
          chk(longint'($signed(out_data)) == last_out, "R8 hold", longint'($signed(out_data)), last_out);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) begin stg_m[k] = 0; act_m[k] = 0; hist[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_data == '0, "R1 out_data", longint'(out_data), 0);

    // R1: zero coefficients give zero
    send(100);
    send(-7);
    drain();
    chk(last_out == 0, "R1 zero coefficient result", last_out, 0);

    // R3: impulse response reproduces the coefficient set
    for (int k = 0; k < 128; k++) wcoef(k, ((k * 37) % 1024) - 512);
    send(1);
    for (int n = 0; n < 130; n++) send(0);
    drain();

    // R2: idle gaps with changing in_data must not be taken
    for (int g = 0; g < 20; g++) begin
      in_data = 10'($urandom);
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R2 no acceptance while idle", exp_q.size(), 0);
    send(37);
    repeat (7) begin in_data = 10'($urandom); @(negedge clk); end
    send(-200);
    drain();

    // R7: most negative values
    for (int k = 0; k < 128; k++) wcoef(k, -512);
    for (int n = 0; n < 128; n++) send(-512);
    drain();
    chk(last_out == 64'sd33554432, "R7 full-scale sum", last_out, 33554432);
    send(511);
    send(-1);
    drain();

    // R5 and R3: random stream, back to back
    for (int k = 0; k < 128; k++) wcoef(k, int'($urandom % 1024) - 512);
    send(int'($urandom % 1024) - 512);
    for (int n = 0; n < 200; n++) begin
      int prev;
      prev = last_acc;
      send(int'($urandom % 1024) - 512);
      chk(last_acc - prev == 10, "R5 accept spacing", last_acc - prev, 10);
    end
    drain();

    // R6: write during a frame is held back for the next sample
    for (int r = 0; r < 4; r++) begin
      fork
        send(int'($urandom % 1024) - 512);
        begin
          repeat (3) @(negedge clk);
          wcoef(r, 300 - 100 * r);
        end
      join
      send(int'($urandom % 1024) - 512);
    end
    // R6: write landing on the accepting edge itself
    fork
      send(123);
      wcoef(0, -512);
    join
    send(-45);
    drain();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule